// File: doc/BRIEF.md
# Asynchronous Interrupt Priority Controller

This block sits next to an instruction sequencer. It keeps track of the asynchronous interrupt sources that are waiting and presents at most one delivery request at a time. Each request carries the vector offset the core should branch to and a small set of flags for the saved machine state. There are three sources:

- a floating-point enabled exception, formed from the exception summary bit and two mode bits;
- a level-sensitive external interrupt line;
- a one-cycle underflow pulse from the decrementer.

The floating-point case always wins, and it does not depend on the external-enable bit. External and decrementer sources are only considered while the external-enable bit is set, and external is preferred over decrementer. An external source stays pending for as long as its line is held. A decrementer event is remembered until it has been delivered once.

A request stays up with constant contents until the core acknowledges it. Acknowledge is sampled on the clock edge. After each acknowledge the request drops for one cycle, and the priority decision is then taken again from the state at that time. Enabling external interrupts is enough to deliver anything already pending; no new event is needed.

Top module: `irq_prio_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released with all inputs idle, `req_valid` is 0.
- R2: With no request outstanding, `fp_exc_summary`=1 together with either bit of `fp_exc_mode` set raises `req_valid` at the next clock edge. The vector is 0x700 and `req_flags`=2'b11 (bit 0 = FP-enabled cause, bit 1 = resume at subsequent instruction). This happens whatever `ext_irq_enable` is, and takes precedence over pending external and decrementer sources.
- R3: `fp_exc_summary`=1 with `fp_exc_mode`=2'b00, or `fp_exc_mode` non-zero with `fp_exc_summary`=0, raises no request.
- R4: The external pending state is `ext_irq_line` registered once. With it set, `ext_irq_enable`=1 and no FP case, a request with vector 0x500 and `req_flags`=2'b00 appears one edge later.
- R5: When external and decrementer are both pending and enabled, external is delivered first.
- R6: Each `dec_underflow` pulse sets a decrementer pending bit. When that bit is the chosen source, the request has vector 0x900 and `req_flags`=2'b00. Acknowledging that request clears the bit.
- R7: Delivering the external source does not clear it. While the line stays high, a new external request follows every acknowledge.
- R8: Releasing `ext_irq_line` before delivery withdraws the external source, and no external request is raised for it later.
- R9: With `ext_irq_enable`=0, external and decrementer sources raise no request. Setting `ext_irq_enable` while a source is pending delivers it with no further event.
- R10: Only one request is outstanding at a time. Vector and flags hold steady until `req_ack`, and triggers that arrive meanwhile add no duplicate request.
- R11: A `req_ack` sampled with `req_valid`=1 drops `req_valid` at that edge. The next decision is made at the following edge.
- R12: A `dec_underflow` pulse in the same cycle as the acknowledge of a decrementer request leaves the pending bit set, so a second decrementer request follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_irq_line | input | 1 | Level-sensitive external interrupt line |
| dec_underflow | input | 1 | One-cycle decrementer underflow pulse |
| fp_exc_summary | input | 1 | Floating-point enabled-exception summary |
| fp_exc_mode | input | 2 | Floating-point exception mode bits |
| ext_irq_enable | input | 1 | External-interrupt enable from machine state |
| req_ack | input | 1 | Core accepts the outstanding request |
| req_valid | output | 1 | Delivery request outstanding |
| req_vector | output | VEC_W (12) | Vector offset of the request |
| req_flags | output | 2 | Extra saved-state flags (bit 0 FP-enabled, bit 1 subsequent instruction) |

## Verification
The bench builds the block with its default parameters. These are a 12-bit vector field and the offsets 0x700, 0x500 and 0x900; the width is the smallest that holds the largest offset, so a truncated or misrouted vector shows up in the compared value. With these values every priority pairing can be reached within a few cycles: FP over external, and external over decrementer. So can the re-evaluation after acknowledge and the coincident pulse and acknowledge of R12. A scoreboard predicts the exact sequence of delivered vectors and flags, and it flags any request that it did not predict.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_FP   = 2'd1,
    SRC_EXT  = 2'd2,
    SRC_DEC  = 2'd3
  } irq_src_e;

  localparam int FLAG_W        = 2;
  localparam int FLAG_FP_CAUSE = 0;
  localparam int FLAG_NEXT_PC  = 1;

  // Fixed priority: FP first (unmasked), then external, then decrementer.
  function automatic irq_src_e pick_source(input logic fp_hit,
                                           input logic ext_pend,
                                           input logic dec_pend,
                                           input logic ext_en);
    if (fp_hit)                return SRC_FP;
    else if (ext_en && ext_pend) return SRC_EXT;
    else if (ext_en && dec_pend) return SRC_DEC;
    else                         return SRC_NONE;
  endfunction

  function automatic logic [FLAG_W-1:0] flags_of(input irq_src_e src);
    logic [FLAG_W-1:0] f;
    f = '0;
    if (src == SRC_FP) begin
      f[FLAG_FP_CAUSE] = 1'b1;
      f[FLAG_NEXT_PC]  = 1'b1;
    end
    return f;
  endfunction

endpackage

// File: rtl/irqc_pending.sv
module irqc_pending (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_line,
  input  logic dec_pulse,
  input  logic dec_retire,
  output logic ext_pend,
  output logic dec_pend
);

  // External source mirrors the line; delivery never touches it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ext_pend <= 1'b0;
    else        ext_pend <= ext_line;
  end

  // Decrementer source is one-shot: a new pulse wins over a retire.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          dec_pend <= 1'b0;
    else if (dec_pulse)  dec_pend <= 1'b1;
    else if (dec_retire) dec_pend <= 1'b0;
  end

  AST_DEC_PULSE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    dec_pulse |=> dec_pend); // R6
  AST_DEC_RETIRE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    dec_retire && !dec_pulse |=> !dec_pend); // R6
  AST_DEC_COINCIDE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    dec_retire && dec_pulse |=> dec_pend); // R12

endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter
  import irqc_pkg::*;
#(
  parameter int unsigned    VEC_W   = 12,
  parameter logic [VEC_W-1:0] VEC_FP  = 'h700,
  parameter logic [VEC_W-1:0] VEC_EXT = 'h500,
  parameter logic [VEC_W-1:0] VEC_DEC = 'h900
) (
  input  logic [1:0]        fp_mode,
  input  logic              fp_summary,
  input  logic              ext_en,
  input  logic              ext_pend,
  input  logic              dec_pend,
  output logic              fp_hit,
  output logic              cand_valid,
  output irq_src_e          cand_src,
  output logic [VEC_W-1:0]  cand_vec,
  output logic [FLAG_W-1:0] cand_flags
);

  assign fp_hit   = (|fp_mode) && fp_summary;
  assign cand_src = pick_source(fp_hit, ext_pend, dec_pend, ext_en);

  always_comb begin
    unique case (cand_src)
      SRC_FP:  cand_vec = VEC_FP;
      SRC_EXT: cand_vec = VEC_EXT;
      SRC_DEC: cand_vec = VEC_DEC;
      default: cand_vec = '0;
    endcase
  end

  assign cand_flags = flags_of(cand_src);
  assign cand_valid = (cand_src != SRC_NONE);

endmodule

// File: rtl/irqc_request.sv
module irqc_request
  import irqc_pkg::*;
#(
  parameter int unsigned VEC_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cand_valid,
  input  irq_src_e          cand_src,
  input  logic [VEC_W-1:0]  cand_vec,
  input  logic [FLAG_W-1:0] cand_flags,
  input  logic              fp_hit,
  input  logic              ack,
  output logic              req_valid,
  output logic [VEC_W-1:0]  req_vec,
  output logic [FLAG_W-1:0] req_flags,
  output logic              dec_retire
);

  irq_src_e req_src;
  logic     take;
  logic     load;

  assign take       = req_valid && ack;
  assign load       = !req_valid && cand_valid;
  assign dec_retire = take && (req_src == SRC_DEC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_valid <= 1'b0;
      req_src   <= SRC_NONE;
      req_vec   <= '0;
      req_flags <= '0;
    end else if (take) begin
      req_valid <= 1'b0;
    end else if (load) begin
      req_valid <= 1'b1;
      req_src   <= cand_src;
      req_vec   <= cand_vec;
      req_flags <= cand_flags;
    end
  end

  AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !ack |=> req_valid && $stable(req_vec) && $stable(req_flags)); // R10
  AST_DROP_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && ack |=> !req_valid); // R11
  AST_FP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid) && $past(fp_hit) |-> req_src == SRC_FP); // R2

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irqc_pkg::*;
#(
  parameter int unsigned      VEC_W   = 12,
  parameter logic [VEC_W-1:0] VEC_FP  = 'h700,
  parameter logic [VEC_W-1:0] VEC_EXT = 'h500,
  parameter logic [VEC_W-1:0] VEC_DEC = 'h900
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_irq_line,
  input  logic             dec_underflow,
  input  logic             fp_exc_summary,
  input  logic [1:0]       fp_exc_mode,
  input  logic             ext_irq_enable,
  input  logic             req_ack,
  output logic             req_valid,
  output logic [VEC_W-1:0] req_vector,
  output logic [1:0]       req_flags
);

  logic              ext_pend;
  logic              dec_pend;
  logic              dec_retire;
  logic              fp_hit;
  logic              cand_valid;
  irq_src_e          cand_src;
  logic [VEC_W-1:0]  cand_vec;
  logic [FLAG_W-1:0] cand_flags;

  irqc_pending u_pending (
    .clk        (clk),
    .rst_n      (rst_n),
    .ext_line   (ext_irq_line),
    .dec_pulse  (dec_underflow),
    .dec_retire (dec_retire),
    .ext_pend   (ext_pend),
    .dec_pend   (dec_pend)
  );

  irqc_arbiter #(
    .VEC_W   (VEC_W),
    .VEC_FP  (VEC_FP),
    .VEC_EXT (VEC_EXT),
    .VEC_DEC (VEC_DEC)
  ) u_arbiter (
    .fp_mode    (fp_exc_mode),
    .fp_summary (fp_exc_summary),
    .ext_en     (ext_irq_enable),
    .ext_pend   (ext_pend),
    .dec_pend   (dec_pend),
    .fp_hit     (fp_hit),
    .cand_valid (cand_valid),
    .cand_src   (cand_src),
    .cand_vec   (cand_vec),
    .cand_flags (cand_flags)
  );

  irqc_request #(
    .VEC_W (VEC_W)
  ) u_request (
    .clk        (clk),
    .rst_n      (rst_n),
    .cand_valid (cand_valid),
    .cand_src   (cand_src),
    .cand_vec   (cand_vec),
    .cand_flags (cand_flags),
    .fp_hit     (fp_hit),
    .ack        (req_ack),
    .req_valid  (req_valid),
    .req_vec    (req_vector),
    .req_flags  (req_flags),
    .dec_retire (dec_retire)
  );

  AST_MASKED_SOURCES: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid) && !$past(fp_hit) |-> $past(ext_irq_enable)); // R9
  AST_EXT_FOLLOWS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ext_pend == $past(ext_irq_line)); // R4

endmodule

// File: tb/test_irq_prio_ctrl.sv
module test_irq_prio_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_irq_line = 1'b0;
  logic        dec_underflow = 1'b0;
  logic        fp_exc_summary = 1'b0;
  logic [1:0]  fp_exc_mode = 2'b00;
  logic        ext_irq_enable = 1'b0;
  logic        req_ack = 1'b0;
  logic        req_valid;
  logic [11:0] req_vector;
  logic [1:0]  req_flags;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic [13:0] exp_q[$];
  string       tag_q[$];

  localparam logic [13:0] EXP_FP  = {2'b11, 12'h700};
  localparam logic [13:0] EXP_EXT = {2'b00, 12'h500};
  localparam logic [13:0] EXP_DEC = {2'b00, 12'h900};

  always #2 clk = ~clk;

  irq_prio_ctrl i_irq_prio_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .ext_irq_line   (ext_irq_line),
    .dec_underflow  (dec_underflow),
    .fp_exc_summary (fp_exc_summary),
    .fp_exc_mode    (fp_exc_mode),
    .ext_irq_enable (ext_irq_enable),
    .req_ack        (req_ack),
    .req_valid      (req_valid),
    .req_vector     (req_vector),
    .req_flags      (req_flags)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic expect_req(input logic [13:0] item, input string req);
    exp_q.push_back(item);
    tag_q.push_back(req);
  endtask

  task automatic chk_valid(input logic v, input string req);
    check(req_valid === v, req, "req_valid", {31'd0, req_valid}, {31'd0, v});
  endtask

  // Monitor: every new request must match the next predicted delivery.
  initial begin
    logic prev;
    prev = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n && req_valid && !prev) begin
        if (exp_q.size() == 0) begin
          n_checks++;
          n_fail++;
          $display("FAIL R10 unexpected request: actual 0x%0h expected none",
                   {req_flags, req_vector});
        end else begin
          logic [13:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check({req_flags, req_vector} === e, t, "delivered flags/vector",
                {18'd0, req_flags, req_vector}, {18'd0, e});
        end
      end
      prev = rst_n && req_valid;
    end
  end

  // Watchdog
  initial begin
    #400000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired (all requirements): actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (3) step();
    chk_valid(1'b0, "R1");
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) begin
      step();
      chk_valid(1'b0, "R1");
    end

    // R2: FP with external enable clear; R10 hold; R11 gap
    fp_exc_mode = 2'b01; fp_exc_summary = 1'b1;
    expect_req(EXP_FP, "R2");
    step();
    chk_valid(1'b1, "R2");
    step(); step();
    check(req_valid && req_vector == 12'h700, "R10", "held vector",
          {20'd0, req_vector}, 32'h700);
    fp_exc_mode = 2'b00; fp_exc_summary = 1'b0;
    step();
    check(req_valid && req_vector == 12'h700, "R10", "held after source gone",
          {20'd0, req_vector}, 32'h700);
    req_ack = 1'b1;
    step();
    chk_valid(1'b0, "R11");
    req_ack = 1'b0;
    step();
    chk_valid(1'b0, "R11");

    // R2 FP beats external; R4 external; R7 repeat; R8 release
    ext_irq_enable = 1'b1; ext_irq_line = 1'b1;
    fp_exc_mode = 2'b10; fp_exc_summary = 1'b1;
    expect_req(EXP_FP, "R2");
    step();
    check(req_valid && req_vector == 12'h700, "R2", "FP over external",
          {20'd0, req_vector}, 32'h700);
    fp_exc_mode = 2'b00; fp_exc_summary = 1'b0;
    req_ack = 1'b1;
    expect_req(EXP_EXT, "R4");
    step();
    chk_valid(1'b0, "R11");
    req_ack = 1'b0;
    step();
    check(req_valid && req_vector == 12'h500, "R4", "external vector",
          {20'd0, req_vector}, 32'h500);
    req_ack = 1'b1;
    expect_req(EXP_EXT, "R7");
    step();
    req_ack = 1'b0;
    step();
    check(req_valid && req_vector == 12'h500, "R7", "external still pending",
          {20'd0, req_vector}, 32'h500);
    req_ack = 1'b1; ext_irq_line = 1'b0;
    step();
    req_ack = 1'b0;
    step();
    chk_valid(1'b0, "R8");
    step();
    chk_valid(1'b0, "R8");

    // R3 incomplete FP condition
    ext_irq_enable = 1'b0;
    fp_exc_summary = 1'b1; fp_exc_mode = 2'b00;
    step(); step();
    chk_valid(1'b0, "R3");
    fp_exc_summary = 1'b0; fp_exc_mode = 2'b11;
    step(); step();
    chk_valid(1'b0, "R3");
    fp_exc_mode = 2'b00;

    // R9 masking, R5 priority, R6 decrementer, R10 no duplicate
    ext_irq_line = 1'b1; dec_underflow = 1'b1;
    step();
    dec_underflow = 1'b0;
    step(); step();
    chk_valid(1'b0, "R9");
    expect_req(EXP_EXT, "R5");
    ext_irq_enable = 1'b1;
    step();
    check(req_valid && req_vector == 12'h500, "R9", "delivered on enable",
          {20'd0, req_vector}, 32'h500);
    req_ack = 1'b1; ext_irq_line = 1'b0;
    expect_req(EXP_DEC, "R6");
    step();
    req_ack = 1'b0;
    step();
    check(req_valid && req_vector == 12'h900, "R6", "decrementer vector",
          {20'd0, req_vector}, 32'h900);
    dec_underflow = 1'b1;
    step();
    dec_underflow = 1'b0;
    check(req_valid && req_vector == 12'h900, "R10", "held during new pulse",
          {20'd0, req_vector}, 32'h900);
    req_ack = 1'b1;
    step();
    req_ack = 1'b0;
    step();
    chk_valid(1'b0, "R10");
    step();
    chk_valid(1'b0, "R6");

    // R12 pulse coinciding with decrementer acknowledge
    dec_underflow = 1'b1;
    expect_req(EXP_DEC, "R6");
    step();
    dec_underflow = 1'b0;
    step();
    chk_valid(1'b1, "R6");
    req_ack = 1'b1; dec_underflow = 1'b1;
    expect_req(EXP_DEC, "R12");
    step();
    req_ack = 1'b0; dec_underflow = 1'b0;
    chk_valid(1'b0, "R11");
    step();
    check(req_valid && req_vector == 12'h900, "R12", "second decrementer",
          {20'd0, req_vector}, 32'h900);
    req_ack = 1'b1;
    step();
    req_ack = 1'b0;
    step();
    chk_valid(1'b0, "R6");

    // R8 line released while masked
    ext_irq_enable = 1'b0; ext_irq_line = 1'b1;
    repeat (3) step();
    ext_irq_line = 1'b0;
    repeat (2) step();
    ext_irq_enable = 1'b1;
    repeat (3) step();
    chk_valid(1'b0, "R8");

    step();
    check(exp_q.size() == 0, "R10", "undelivered predictions",
          exp_q.size(), 32'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule